// File: doc/BRIEF.md
# Palette-fed TMDS Lane Encoder

This block turns a stream of 8-bit palette indices into the 10-bit symbols of one TMDS lane. On every pixel clock it takes an index, a data-enable flag and a two-bit control value. While data-enable is high and the index lies in the colour range (0 to 239), the index addresses a writable colour table. The 8-bit component value read from that table is then TMDS data-encoded. The encoding first minimises transitions inside the symbol and then keeps the ones and zeros balanced over time, using a small running accumulator.

The sixteen top indices (240 to 255) carry no colour. Each of them emits one of the four TMDS control symbols, so control signalling can travel inside the pixel stream itself. During blanking (data-enable low), the two control bits select the control symbol directly. Every control symbol clears the balance accumulator.

The colour table is loaded through a plain address/data/write-enable port. Its registered read adds one cycle, and the pipeline is built around that cycle. A 10-bit symbol and a valid strobe leave the block two clock edges after the index is sampled. The serialiser and the line driver sit downstream.

Top module: `pal_tmds_lane`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sym_out` becomes 0 and `sym_vld` becomes 0. After reset is released, `sym_vld` stays low through the first edge and is high from the second edge onward.
- R2: The symbol for the inputs sampled at edge k appears on `sym_out` after edge k+1. A new symbol follows every cycle, with no gaps.
- R3: With `pix_de` low, the output is the control symbol selected by `ctl_in`, and `pix_idx` has no effect. Written bit 9 down to bit 0, the codes are: 00 gives 1101010100, 01 gives 0010101011, 10 gives 0101010100, 11 gives 1010101011.
- R4: With `pix_de` high and `pix_idx` in 240..255, the output is the R3 control symbol for code (`pix_idx` − 240) mod 4. Both `ctl_in` and the upper index bits have no effect.
- R5: With `pix_de` high and `pix_idx` in 0..239, the byte stored at that table entry is TMDS data-encoded. A table write at edge k is used by pixels sampled at edge k+1 and later.
- R6: Stage one chains the byte bit by bit from bit 0. It uses XNOR when the byte has more than four ones, or exactly four ones with bit 0 clear; otherwise it uses XOR. Symbol bit 8 is 1 for XOR and 0 for XNOR.
- R7: Stage two inverts bits 7:0 and sets bit 9 when the running disparity and the imbalance of the stage-one byte have the same non-zero sign. When either of them is zero, bit 9 is the complement of bit 8, and bits 7:0 are inverted exactly when bit 8 is 0.
- R8: Every control symbol clears the running disparity. The next data symbol is therefore encoded as if the disparity were zero.
- R9: Counted over the data symbols since the last control symbol, ones minus zeros over all 10 bits stays within −8..+8. The accumulator holds half of this value in 4 signed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_idx | input | 8 | Palette index for this pixel |
| pix_de | input | 1 | High during active video |
| ctl_in | input | 2 | Control bits used during blanking |
| lut_we | input | 1 | Colour table write enable |
| lut_waddr | input | 8 | Colour table write address (0..239 stored) |
| lut_wdata | input | 8 | Colour table write data |
| sym_out | output | 10 | TMDS symbol, bit 0 sent first |
| sym_vld | output | 1 | Symbol valid strobe |

## Verification
Every symbol, whether data or control, is due after the second rising edge that follows the sample of its index. The bench drives inputs on falling edges and carries each expected symbol for exactly two steps before comparing it, so each comparison lines up with the pipeline depth. Table writes take effect one edge after the write, so new entries are only read by pixels driven afterwards. The disparity bound is checked from the emitted symbols alone, without reference to the design's internals: a tally of ones minus zeros restarts at each control symbol.

// File: rtl/pal_tmds_pkg.sv
// Shared constants and the control-symbol mapping for the palette TMDS lane.
// Assumes a single 10-bit lane; symbols are listed bit 9 down to bit 0.
package pal_tmds_pkg;

    localparam int SYM_W  = 10;
    localparam int BYTE_W = 8;

    typedef logic [SYM_W-1:0]  sym_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [1:0]        ctl_code_t;

    // Maps a two-bit control code to its fixed 10-bit control symbol.
    function automatic sym_t ctl_symbol(input ctl_code_t code);
        case (code)
            2'd0:    return 10'b1101010100;
            2'd1:    return 10'b0010101011;
            2'd2:    return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

endpackage

// File: rtl/pal_colour_ram.sv
// Colour table: single write port, one registered read port.
// Assumes entries at or above DEPTH are not stored; reads of them return 0.
// A write and a read of the same entry on one edge return the old value.
module pal_colour_ram #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 240
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_ok;
    logic              rd_ok;

    // Bound checks only exist when the index space exceeds the table.
    generate
        if (DEPTH < (1 << IDX_W)) begin : g_bounded
            assign wr_ok = wr_addr < LIMIT;
            assign rd_ok = rd_addr < LIMIT;
        end else begin : g_full
            assign wr_ok = 1'b1;
            assign rd_ok = 1'b1;
        end
    endgenerate

    // Stores one entry per cycle when enabled and in range.
    always_ff @(posedge clk) begin
        if (wr_en && wr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read; out-of-range addresses read as zero.
    always_ff @(posedge clk) begin
        rd_data <= rd_ok ? mem[rd_addr] : '0;
    end

endmodule

// File: rtl/tmds_lane_enc.sv
// TMDS symbol stage: transition-minimising chain, then DC balancing with a
// running half-disparity accumulator, then the output register.
// Assumes use_ctl/ctl_code/pix arrive together and are aligned with adv.
module tmds_lane_enc
    import pal_tmds_pkg::*;
#(
    parameter int ACC_W = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    input  logic      use_ctl,
    input  ctl_code_t ctl_code,
    input  byte_t     pix,
    output sym_t      sym_o
);
    localparam int WW = ACC_W + 2;

    logic [3:0]              n1_d;
    logic                    use_xnor;
    logic [8:0]              qm;
    logic [3:0]              n1_q;
    logic signed [WW-1:0]    bal_h;
    logic signed [WW-1:0]    acc_w;
    logic signed [WW-1:0]    nxt_w;
    logic signed [WW-1:0]    qm8_w;
    logic signed [WW-1:0]    nqm8_w;
    logic signed [ACC_W-1:0] acc_q;
    logic                    tie;
    logic                    flip;
    sym_t                    data_sym;
    sym_t                    sym_q;

    // Chooses the chaining operation from the byte's population count.
    always_comb begin
        n1_d     = 4'($countones(pix));
        use_xnor = (n1_d > 4'd4) || ((n1_d == 4'd4) && !pix[0]);
    end

    // Builds the transition-minimised 9-bit word bit by bit.
    always_comb begin
        logic prev;
        prev  = pix[0];
        qm[0] = prev;
        for (int i = 1; i < BYTE_W; i++) begin
            prev  = use_xnor ? ~(prev ^ pix[i]) : (prev ^ pix[i]);
            qm[i] = prev;
        end
        qm[8] = ~use_xnor;
    end

    // Half imbalance of the chained byte, and widened copies for arithmetic.
    always_comb begin
        n1_q      = 4'($countones(qm[7:0]));
        bal_h     = $signed({{(WW-4){1'b0}}, n1_q}) - $signed(WW'(4));
        acc_w     = WW'(acc_q);
        qm8_w     = '0;
        qm8_w[0]  = qm[8];
        nqm8_w    = '0;
        nqm8_w[0] = ~qm[8];
        tie       = (acc_w == 0) || (bal_h == 0);
        flip      = ((acc_w > 0) && (bal_h > 0)) || ((acc_w < 0) && (bal_h < 0));
    end

    // Picks the balanced symbol and the next half-disparity.
    always_comb begin
        if (tie) begin
            data_sym = {~qm[8], qm[8], (qm[8] ? qm[7:0] : ~qm[7:0])};
            nxt_w    = qm[8] ? (acc_w + bal_h) : (acc_w - bal_h);
        end else if (flip) begin
            data_sym = {1'b1, qm[8], ~qm[7:0]};
            nxt_w    = acc_w + qm8_w - bal_h;
        end else begin
            data_sym = {1'b0, qm[8], qm[7:0]};
            nxt_w    = acc_w - nqm8_w + bal_h;
        end
    end

    // Registers the symbol; control symbols clear the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= '0;
            acc_q <= '0;
        end else if (adv) begin
            if (use_ctl) begin
                sym_q <= ctl_symbol(ctl_code);
                acc_q <= '0;
            end else begin
                sym_q <= data_sym;
                acc_q <= ACC_W'(nxt_w);
            end
        end
    end

    assign sym_o = sym_q;

    // R6: heavy bytes use XNOR chaining, flagged by bit 8 low.
    p_xnor_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !use_ctl && ($countones(pix) > 4)) |=> (sym_o[8] == 1'b0));

    // R6: light bytes use XOR chaining, flagged by bit 8 high.
    p_xor_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !use_ctl && ($countones(pix) < 4)) |=> (sym_o[8] == 1'b1));

    // R7: with zero disparity, bit 9 is the complement of bit 8.
    p_tie_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !use_ctl && (acc_q == 0)) |=> (sym_o[9] != sym_o[8]));

    // R9: the stored half-disparity stays within -4..+4.
    p_acc_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q >= -4) && (acc_q <= 4));

endmodule

// File: rtl/pal_tmds_lane.sv
// Palette-fed TMDS lane: index -> colour table (1 cycle) -> TMDS encoder (1 cycle).
// Indices at or above NUM_COLOURS select control symbols by their offset mod 4.
// Assumes pix_de, ctl_in and pix_idx are sampled together every pixel clock.
module pal_tmds_lane
    import pal_tmds_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int NUM_COLOURS = 240,
    parameter int ACC_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic             pix_de,
    input  logic [1:0]       ctl_in,
    input  logic             lut_we,
    input  logic [IDX_W-1:0] lut_waddr,
    input  logic [7:0]       lut_wdata,
    output logic [9:0]       sym_out,
    output logic             sym_vld
);
    localparam logic [IDX_W-1:0] FIRST_CTL = IDX_W'(NUM_COLOURS);

    logic      is_rsv;
    ctl_code_t rsv_code;
    logic      s1_vld;
    logic      s1_ctl;
    ctl_code_t s1_code;
    byte_t     lut_q;
    logic      vld_q;
    sym_t      enc_sym;

    // Reserved-index decode only exists when some indices are left over.
    generate
        if (NUM_COLOURS < (1 << IDX_W)) begin : g_rsv
            assign is_rsv = pix_idx >= FIRST_CTL;
        end else begin : g_no_rsv
            assign is_rsv = 1'b0;
        end
    endgenerate

    assign rsv_code = 2'(pix_idx - FIRST_CTL);

    // Stage one: holds control selection alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_ctl  <= 1'b1;
            s1_code <= '0;
        end else begin
            s1_vld  <= 1'b1;
            s1_ctl  <= !pix_de || is_rsv;
            s1_code <= pix_de ? rsv_code : ctl_in;
        end
    end

    pal_colour_ram #(
        .IDX_W  (IDX_W),
        .DATA_W (BYTE_W),
        .DEPTH  (NUM_COLOURS)
    ) u_lut (
        .clk     (clk),
        .wr_en   (lut_we),
        .wr_addr (lut_waddr),
        .wr_data (lut_wdata),
        .rd_addr (pix_idx),
        .rd_data (lut_q)
    );

    tmds_lane_enc #(
        .ACC_W (ACC_W)
    ) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (s1_vld),
        .use_ctl  (s1_ctl),
        .ctl_code (s1_code),
        .pix      (lut_q),
        .sym_o    (enc_sym)
    );

    // Stage two valid: follows the stage-one valid by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= s1_vld;
        end
    end

    assign sym_out = enc_sym;
    assign sym_vld = vld_q;

    // R1: reset clears the outputs on the next edge.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> ((sym_out == '0) && !sym_vld));

    // R2: valid is high once two edges have passed out of reset.
    p_vld_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> sym_vld);

    // R3: blanking emits the control symbol of ctl_in two edges later.
    p_blank_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && !$past(pix_de, 2)) |-> (sym_out == ctl_symbol($past(ctl_in, 2))));

    // R4: a reserved index emits the control symbol of its offset.
    p_reserved_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_vld && $past(pix_de, 2) && ($past(pix_idx, 2) >= FIRST_CTL))
        |-> (sym_out == ctl_symbol(2'($past(pix_idx, 2) - FIRST_CTL))));

endmodule

// File: tb/pal_tmds_lane_bench.sv
`timescale 1ns/1ps
module pal_tmds_lane_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pix_idx;
    logic       pix_de;
    logic [1:0] ctl_in;
    logic       lut_we;
    logic [7:0] lut_waddr;
    logic [7:0] lut_wdata;
    logic [9:0] sym_out;
    logic       sym_vld;

    always #2 clk = ~clk;

    pal_tmds_lane u_pal_tmds_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_idx   (pix_idx),
        .pix_de    (pix_de),
        .ctl_in    (ctl_in),
        .lut_we    (lut_we),
        .lut_waddr (lut_waddr),
        .lut_wdata (lut_wdata),
        .sym_out   (sym_out),
        .sym_vld   (sym_vld)
    );

    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;
    logic [7:0] m_lut [256];
    int         m_cnt  = 0;
    int         o_disp = 0;
    logic [9:0] e1, e2;
    bit         v1 = 1'b0, v2 = 1'b0;
    string      t1, t2;

    // Stimulus {idx, de, ctl, expected symbol, requirement}; each follows a blank.
    localparam logic [24:0] VEC [15] = '{
        {8'h00, 1'b1, 2'd0, 10'h100, 4'd5},   // R5 colour 0
        {8'h01, 1'b1, 2'd0, 10'h1FF, 4'd6},   // R6 xor chain
        {8'h0F, 1'b1, 2'd0, 10'h105, 4'd6},   // R6 four ones, bit0 set
        {8'h1E, 1'b1, 2'd0, 10'h25F, 4'd6},   // R6 four ones, bit0 clear
        {8'hC8, 1'b1, 2'd0, 10'h200, 4'd6},   // R6 entry holds 0xFF
        {8'h10, 1'b1, 2'd0, 10'h1F0, 4'd7},   // R7 balanced byte
        {8'hF0, 1'b1, 2'd3, 10'h354, 4'd4},   // R4 first reserved
        {8'hF5, 1'b1, 2'd0, 10'h0AB, 4'd4},   // R4 upper bits ignored
        {8'hFE, 1'b1, 2'd1, 10'h154, 4'd4},   // R4
        {8'hFF, 1'b1, 2'd2, 10'h2AB, 4'd4},   // R4 last index
        {8'h33, 1'b0, 2'd0, 10'h354, 4'd3},   // R3
        {8'h00, 1'b0, 2'd1, 10'h0AB, 4'd3},   // R3
        {8'hF2, 1'b0, 2'd2, 10'h154, 4'd3},   // R3 reserved index while blank
        {8'h80, 1'b0, 2'd3, 10'h2AB, 4'd3},   // R3
        {8'hEF, 1'b1, 2'd0, 10'h2F0, 4'd5}    // R5 last colour entry
    };

    function automatic logic [9:0] ctl_ref(input logic [1:0] c);
        case (c)
            2'd0:    return 10'h354;
            2'd1:    return 10'h0AB;
            2'd2:    return 10'h154;
            default: return 10'h2AB;
        endcase
    endfunction

    task automatic chk(input logic [9:0] act, input logic [9:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference encoder with full-scale disparity held in m_cnt.
    task automatic model(input logic [7:0] idx, input bit de, input logic [1:0] ctl,
                         output logic [9:0] s);
        logic [7:0] d;
        logic [8:0] q;
        int ones, bal;
        if (!de || idx >= 8'd240) begin
            s = ctl_ref(de ? 2'(idx - 8'd240) : ctl);
            m_cnt = 0;
            return;
        end
        d = m_lut[idx];
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        q[0] = d[0];
        if (ones > 4 || (ones == 4 && d[0] == 1'b0)) begin
            for (int i = 1; i < 8; i++) q[i] = ~(q[i-1] ^ d[i]);
            q[8] = 1'b0;
        end else begin
            for (int i = 1; i < 8; i++) q[i] = q[i-1] ^ d[i];
            q[8] = 1'b1;
        end
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(q[i]);
        bal = 2 * ones - 8;
        if (m_cnt == 0 || bal == 0) begin
            s = {~q[8], q[8], (q[8] ? q[7:0] : ~q[7:0])};
            m_cnt += q[8] ? bal : -bal;
        end else if ((m_cnt > 0 && bal > 0) || (m_cnt < 0 && bal < 0)) begin
            s = {1'b1, q[8], ~q[7:0]};
            m_cnt += 2 * int'(q[8]) - bal;
        end else begin
            s = {1'b0, q[8], q[7:0]};
            m_cnt += bal - 2 * (1 - int'(q[8]));
        end
    endtask

    // One pixel step: compare the output due now, then drive the next input.
    task automatic step(input logic [7:0] idx, input bit de, input logic [1:0] ctl,
                        input bit fix, input logic [9:0] fexp, input string req);
        logic [9:0] s;
        @(negedge clk);
        if (v2) begin
            chk(sym_out, e2, t2);
            if (sym_out == 10'h354 || sym_out == 10'h0AB ||
                sym_out == 10'h154 || sym_out == 10'h2AB) begin
                o_disp = 0;
            end else begin
                o_disp += 2 * $countones(sym_out) - 10;
                checks++;
                if (o_disp > 8 || o_disp < -8) begin
                    errors++;
                    $display("FAIL R9 actual=%0d expected=within -8..8", o_disp);
                end
            end
        end
        e2 = e1; v2 = v1; t2 = t1;
        model(idx, de, ctl, s);
        e1 = fix ? fexp : s;
        v1 = 1'b1;
        t1 = req;
        pix_idx = idx; pix_de = de; ctl_in = ctl; lut_we = 1'b0;
    endtask

    task automatic lut_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        lut_we = 1'b1; lut_waddr = a; lut_wdata = d;
        pix_de = 1'b0; ctl_in = 2'd0;
        m_lut[a] = d;
        v1 = 1'b0; v2 = 1'b0; m_cnt = 0; o_disp = 0;
    endtask

    task automatic blank(input string req);
        step(8'h00, 1'b0, 2'd0, 1'b0, 10'h0, req);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pix_idx = '0; pix_de = 1'b0; ctl_in = '0;
        lut_we = 1'b0; lut_waddr = '0; lut_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sym_out, 10'h000, "R1 reset symbol");
        chk({9'd0, sym_vld}, 10'h000, "R1 reset valid");
        rst_n = 1'b1;
        @(negedge clk);
        chk({9'd0, sym_vld}, 10'h000, "R1 valid after one edge");
        @(negedge clk);
        chk({9'd0, sym_vld}, 10'h001, "R2 valid after two edges");

        for (int i = 0; i < 240; i++) lut_write(8'(i), 8'(i));
        lut_write(8'd200, 8'hFF);

        // Table walk: each vector after a blank, so disparity starts at zero.
        for (int v = 0; v < 15; v++) begin
            blank("R3 blank before vector");
            step(VEC[v][24:17], VEC[v][16], VEC[v][15:14], 1'b1, VEC[v][13:4],
                 $sformatf("R%0d table row %0d", VEC[v][3:0], v));
        end
        blank("R3 flush"); blank("R3 flush");

        // R8 and R7: disparity clearing and the inverting branch.
        blank("R3");
        step(8'h00, 1'b1, 2'd0, 1'b1, 10'h100, "R8 first data");
        blank("R8 control between");
        step(8'h00, 1'b1, 2'd0, 1'b1, 10'h100, "R8 disparity cleared");
        step(8'h00, 1'b1, 2'd0, 1'b1, 10'h3FF, "R7 invert branch");
        step(8'h00, 1'b1, 2'd0, 1'b1, 10'h100, "R7 else branch");
        blank("R3 flush"); blank("R3 flush");

        // R5: rewritten entry seen by the next pixel.
        lut_write(8'd5, 8'h00);
        blank("R3");
        step(8'd5, 1'b1, 2'd0, 1'b1, 10'h100, "R5 rewritten entry");
        blank("R3 flush"); blank("R3 flush");

        // Random table contents and stream checked against the reference.
        for (int i = 0; i < 240; i++) lut_write(8'(i), 8'($urandom_range(0, 255)));
        blank("R3");
        for (int n = 0; n < 600; n++) begin
            step(8'($urandom_range(0, 255)), ($urandom_range(0, 9) != 0),
                 2'($urandom_range(0, 3)), 1'b0, 10'h0, "R2 R5 R7 stream");
        end
        for (int n = 0; n < 200; n++) begin
            step(8'($urandom_range(0, 239)), 1'b1, 2'd0, 1'b0, 10'h0, "R7 R9 long run");
        end
        blank("R3 flush"); blank("R3 flush"); blank("R3 flush");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule